// File: doc/BRIEF.md
# Status Flags and Branch Unit

This block holds the five condition flags and the word-addressed program counter of a small 32-bit load/store processor. The flags are refreshed from the 33-bit ALU result whenever an arithmetic, multiply, invert, shift or rotate instruction retires. On each write-back strobe the program counter advances to the next word, jumps to an absolute target, or returns to zero.

A combinational branch decision is always available. It is formed from the branch instruction's 4-bit condition selector and the flags as they stand before the write-back edge. A halt instruction clears both the counter and the flags, so the processor restarts from address zero in a known state. The surrounding control sequencer supplies the instruction word, the ALU result and a one-cycle write-phase strobe. It reads back the counter to fetch the next instruction.

Top module: `status_branch_unit`

## Requirements
- R1: A synchronous active-high reset `rst` clears `pc_q` and `status_q` to zero at the next rising clock edge.
- R2: On a clock edge where `wr_phase` is low, `pc_q` and `status_q` keep their values, whatever the instruction.
- R3: On a write-phase edge with an instruction that is neither halt nor a taken branch, `pc_q` increments by one, and 4095 wraps to 0.
- R4: The opcode is `instr[31:28]`. On a write-phase edge with opcode 4, 5, 6, 7 or 8, `status_q` loads the flags from `alu_res`. Bit 0 is carry = `alu_res[32]`. Bit 1 is even = NOT `alu_res[0]`. Bit 2 is parity = XOR of `alu_res[31:0]`. Bit 3 is zero, set when `alu_res[31:0]` is all zeros. Bit 4 is negative = `alu_res[31]`.
- R5: On a write-phase edge with any opcode outside 4..8 other than halt (0x0–0x3, 0x9–0xD, 0xF), `status_q` is unchanged.
- R6: `br_taken` is high only when the opcode is 1. With the condition selector `instr[27:24]`:
  - selector 0 always branches;
  - selectors 1, 2, 3, 4 and 5 branch when `status_q` bit 0, 1, 2, 3 or 4 is set, respectively;
  - selectors 6–15 never branch.
- R7: On a write-phase edge where `br_taken` is high, `pc_q` loads `instr[11:0]`.
- R8: On a write-phase edge with opcode 0xE (halt), `pc_q` and `status_q` become zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_phase | input | 1 | Write-back strobe; state changes only when high |
| instr | input | 32 | Current instruction word |
| alu_res | input | 33 | ALU result, bit 32 is carry out |
| status_q | output | 5 | Flags: {negative, zero, parity, even, carry} |
| br_taken | output | 1 | Branch decision for the current instruction |
| pc_q | output | 12 | Program counter, in words |

## Verification
The checker assumes that `instr` and `alu_res` are stable around each rising edge. It also assumes `wr_phase` is a plain level sampled at that edge, so a `$past` of the instruction names the instruction that retired. The bench drives every input at the falling edge and holds it through the following rising edge. It walks the opcode and condition selector values across ordinary, halt, never-taken and wrap-around cases. Strobe-low cycles are mixed in, so that hold behaviour is exercised alongside updates.

// File: rtl/sbu_pkg.sv
package sbu_pkg;

    localparam int OPC_W = 4;
    localparam int SEL_W = 4;

    localparam logic [OPC_W-1:0] OPC_BRANCH = 4'h1;
    localparam logic [OPC_W-1:0] OPC_ADD    = 4'h4;
    localparam logic [OPC_W-1:0] OPC_ROTATE = 4'h8;
    localparam logic [OPC_W-1:0] OPC_HALT   = 4'hE;

    localparam logic [SEL_W-1:0] SEL_ALWAYS  = 4'd0;
    localparam logic [SEL_W-1:0] SEL_CARRY   = 4'd1;
    localparam logic [SEL_W-1:0] SEL_EVEN    = 4'd2;
    localparam logic [SEL_W-1:0] SEL_ODD_PAR = 4'd3;
    localparam logic [SEL_W-1:0] SEL_ZERO    = 4'd4;
    localparam logic [SEL_W-1:0] SEL_NEG     = 4'd5;

    typedef struct packed {
        logic neg;
        logic zero;
        logic par;
        logic even;
        logic carry;
    } flags_t;

    function automatic logic updates_flags(input logic [OPC_W-1:0] op);
        return (op >= OPC_ADD) && (op <= OPC_ROTATE);
    endfunction

    function automatic logic cond_met(input logic [SEL_W-1:0] sel, input flags_t f);
        logic hit;
        case (sel)
            SEL_ALWAYS:  hit = 1'b1;
            SEL_CARRY:   hit = f.carry;
            SEL_EVEN:    hit = f.even;
            SEL_ODD_PAR: hit = f.par;
            SEL_ZERO:    hit = f.zero;
            SEL_NEG:     hit = f.neg;
            default:     hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/sbu_flag_gen.sv
module sbu_flag_gen
    import sbu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W:0] res,
    output flags_t          flags
);
    always_comb begin
        flags.carry = res[DATA_W];
        flags.neg   = res[DATA_W-1];
        flags.zero  = (res[DATA_W-1:0] == '0);
        flags.par   = ^res[DATA_W-1:0];
        flags.even  = ~res[0];
    end
endmodule

// File: rtl/sbu_cond_eval.sv
module sbu_cond_eval
    import sbu_pkg::*;
(
    input  logic [OPC_W-1:0] op,
    input  logic [SEL_W-1:0] sel,
    input  flags_t           flags,
    output logic             taken
);
    always_comb begin
        taken = (op == OPC_BRANCH) && cond_met(sel, flags);
    end
endmodule

// File: rtl/sbu_pc_reg.sv
module sbu_pc_reg #(
    parameter int PC_W = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_phase,
    input  logic            halt,
    input  logic            jump,
    input  logic [PC_W-1:0] target,
    output logic [PC_W-1:0] pc
);
    localparam logic [PC_W-1:0] STEP = PC_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (wr_phase) begin
            if (halt)
                pc <= '0;
            else if (jump)
                pc <= target;
            else
                pc <= pc + STEP;
        end
    end
endmodule

// File: rtl/sbu_status_reg.sv
module sbu_status_reg
    import sbu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_phase,
    input  logic   halt,
    input  logic   load,
    input  flags_t next_flags,
    output flags_t flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else if (wr_phase) begin
            if (halt)
                flags <= '0;
            else if (load)
                flags <= next_flags;
        end
    end
endmodule

// File: rtl/status_branch_unit.sv
module status_branch_unit
    import sbu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PC_W   = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_phase,
    input  logic [DATA_W-1:0] instr,
    input  logic [DATA_W:0]   alu_res,
    output logic [4:0]        status_q,
    output logic              br_taken,
    output logic [PC_W-1:0]   pc_q
);
    localparam int OP_LSB  = DATA_W - OPC_W;
    localparam int SEL_LSB = OP_LSB - SEL_W;

    logic [OPC_W-1:0] op;
    logic [SEL_W-1:0] sel;
    logic [PC_W-1:0]  target;
    logic             is_halt;
    logic             unused_mid;
    flags_t           new_flags;
    flags_t           cur_flags;

    assign op         = instr[DATA_W-1:OP_LSB];
    assign sel        = instr[OP_LSB-1:SEL_LSB];
    assign target     = instr[PC_W-1:0];
    assign unused_mid = ^instr[SEL_LSB-1:PC_W];
    assign is_halt    = (op == OPC_HALT);

    sbu_flag_gen #(.DATA_W(DATA_W)) u_flag_gen (
        .res   (alu_res),
        .flags (new_flags)
    );

    sbu_cond_eval u_cond_eval (
        .op    (op),
        .sel   (sel),
        .flags (cur_flags),
        .taken (br_taken)
    );

    sbu_status_reg u_status_reg (
        .clk        (clk),
        .rst        (rst),
        .wr_phase   (wr_phase),
        .halt       (is_halt),
        .load       (updates_flags(op)),
        .next_flags (new_flags),
        .flags      (cur_flags)
    );

    sbu_pc_reg #(.PC_W(PC_W)) u_pc_reg (
        .clk      (clk),
        .rst      (rst),
        .wr_phase (wr_phase),
        .halt     (is_halt),
        .jump     (br_taken),
        .target   (target),
        .pc       (pc_q)
    );

    assign status_q = cur_flags;
endmodule

// File: rtl/sbu_checker.sv
module sbu_checker #(
    parameter int DATA_W = 32,
    parameter int PC_W   = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_phase,
    input logic [DATA_W-1:0] instr,
    input logic [DATA_W:0]   alu_res,
    input logic [4:0]        status_q,
    input logic              br_taken,
    input logic [PC_W-1:0]   pc_q
);
    logic [3:0] op;
    logic       arith;
    assign op    = instr[DATA_W-1 -: 4];
    assign arith = (op >= 4'h4) && (op <= 4'h8);

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_phase |=> ($stable(pc_q) && $stable(status_q))); // R2

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (wr_phase && op != 4'hE && !br_taken) |=> (pc_q == PC_W'($past(pc_q) + 1'b1))); // R3

    AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_phase && arith) |=> (status_q[0] == $past(alu_res[DATA_W]) &&
                                 status_q[4] == $past(alu_res[DATA_W-1]) &&
                                 status_q[1] == !$past(alu_res[0]))); // R4

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_phase && !arith && op != 4'hE) |=> $stable(status_q)); // R5

    AST_NO_BRANCH_OTHER_OP: assert property (@(posedge clk) disable iff (rst)
        (op != 4'h1) |-> !br_taken); // R6

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (wr_phase && br_taken) |=> (pc_q == $past(instr[PC_W-1:0]))); // R7

    AST_HALT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_phase && op == 4'hE) |=> (pc_q == '0 && status_q == '0)); // R8
endmodule

bind status_branch_unit sbu_checker #(.DATA_W(DATA_W), .PC_W(PC_W)) u_sbu_checker (
    .clk      (clk),
    .rst      (rst),
    .wr_phase (wr_phase),
    .instr    (instr),
    .alu_res  (alu_res),
    .status_q (status_q),
    .br_taken (br_taken),
    .pc_q     (pc_q)
);

// File: tb/status_branch_unit_test.sv
module status_branch_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_phase = 1'b0;
    logic [31:0] instr = '0;
    logic [32:0] alu_res = '0;
    logic [4:0]  status_q;
    logic        br_taken;
    logic [11:0] pc_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [11:0] m_pc = '0;
    logic [4:0]  m_st = '0;

    always #5 clk = ~clk;

    status_branch_unit uut (
        .clk(clk), .rst(rst), .wr_phase(wr_phase), .instr(instr),
        .alu_res(alu_res), .status_q(status_q), .br_taken(br_taken), .pc_q(pc_q)
    );

    // Stimulus table: {wr_phase, instr, alu_res}
    localparam int NV = 20;
    localparam logic [65:0] VEC [NV] = '{
        {1'b1, 32'h4000_0001, 33'h1_0000_0000}, // add: carry, zero, even
        {1'b1, 32'h1100_0040, 33'h0_0000_0000}, // branch on carry
        {1'b1, 32'h5000_0002, 33'h0_8000_0001}, // mul: negative
        {1'b1, 32'h1500_0123, 33'h0_0000_0000}, // branch on negative
        {1'b1, 32'h1400_0200, 33'h0_0000_0000}, // branch on zero, not taken
        {1'b1, 32'h6000_0003, 33'h0_0000_0007}, // invert: odd parity
        {1'b1, 32'h1300_0300, 33'h0_0000_0000}, // branch on parity
        {1'b1, 32'h1200_0400, 33'h0_0000_0000}, // branch on even, not taken
        {1'b1, 32'h1000_0FFF, 33'h0_0000_0000}, // always to 0xFFF
        {1'b1, 32'h2800_0001, 33'h1_FFFF_FFFF}, // load: wrap, flags hold
        {1'b1, 32'h1700_0010, 33'h0_0000_0000}, // selector 7 never
        {1'b1, 32'h1F00_0020, 33'h0_0000_0000}, // selector 15 never
        {1'b1, 32'h7000_0004, 33'h0_0000_0000}, // shift: zero
        {1'b0, 32'hE000_0000, 33'h1_FFFF_FFFF}, // halt, strobe low
        {1'b0, 32'h1000_0555, 33'h0_0000_0000}, // branch, strobe low
        {1'b1, 32'h3800_0005, 33'h1_2345_6789}, // store: flags hold
        {1'b1, 32'h8000_0006, 33'h0_0000_0002}, // rotate
        {1'b1, 32'h1200_0777, 33'h0_0000_0000}, // branch on even, taken
        {1'b1, 32'hE000_0000, 33'h1_8000_0000}, // halt
        {1'b1, 32'h9000_0000, 33'h0_0000_0001}  // opcode 9: step only
    };

    function automatic logic [4:0] ref_flags(input logic [32:0] r);
        return {r[31], (r[31:0] == 32'd0), ^r[31:0], ~r[0], r[32]};
    endfunction

    function automatic logic ref_taken(input logic [31:0] i, input logic [4:0] st);
        if (i[31:28] != 4'h1) return 1'b0;
        case (i[27:24])
            4'd0: return 1'b1;
            4'd1: return st[0];
            4'd2: return st[1];
            4'd3: return st[2];
            4'd4: return st[3];
            4'd5: return st[4];
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic [31:0] i, input logic [32:0] r);
        logic       t;
        logic [3:0] op;
        string      pc_tag, st_tag;
        @(negedge clk);
        wr_phase = w; instr = i; alu_res = r;
        #1;
        op = i[31:28];
        t  = ref_taken(i, m_st);
        chk("R6", "br_taken", {31'd0, br_taken}, {31'd0, t});
        if (op == 4'hE && w)      pc_tag = "R8";
        else if (!w)              pc_tag = "R2";
        else if (t)               pc_tag = "R7";
        else                      pc_tag = "R3";
        if (op == 4'hE && w)      st_tag = "R8";
        else if (!w)              st_tag = "R2";
        else if (op >= 4'h4 && op <= 4'h8) st_tag = "R4";
        else                      st_tag = "R5";
        if (w) begin
            if (op == 4'hE) begin
                m_pc = '0; m_st = '0;
            end else begin
                m_pc = t ? i[11:0] : m_pc + 12'd1;
                if (op >= 4'h4 && op <= 4'h8) m_st = ref_flags(r);
            end
        end
        @(posedge clk); #1;
        chk(pc_tag, "pc_q", {20'd0, pc_q}, {20'd0, m_pc});
        chk(st_tag, "status_q", {27'd0, status_q}, {27'd0, m_st});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        chk("R1", "pc_q after reset", {20'd0, pc_q}, 32'd0);
        chk("R1", "status_q after reset", {27'd0, status_q}, 32'd0);
        @(negedge clk); rst = 1'b0;

        for (int k = 0; k < NV; k++)
            step(VEC[k][65], VEC[k][64:33], VEC[k][32:0]);

        // Directed: reset in the middle of activity (R1)
        step(1'b1, 32'h4000_0000, 33'h1_8000_0000);
        @(negedge clk); rst = 1'b1; wr_phase = 1'b1; instr = 32'h1000_0ABC;
        @(posedge clk); #1;
        chk("R1", "pc_q mid reset", {20'd0, pc_q}, 32'd0);
        chk("R1", "status_q mid reset", {27'd0, status_q}, 32'd0);
        @(negedge clk); rst = 1'b0; m_pc = '0; m_st = '0;

        // Directed: wrap from 4095 by plain step (R3)
        step(1'b1, 32'h1000_0FFE, 33'h0);
        step(1'b1, 32'h0000_0000, 33'h0);
        step(1'b1, 32'h0000_0000, 33'h0);
        chk("R3", "pc_q wrapped", {20'd0, pc_q}, 32'd0);

        // Directed: negative with carry, then branch on zero not taken (R6)
        step(1'b1, 32'h5000_0000, 33'h1_FFFF_FFFE);
        step(1'b1, 32'h1400_0100, 33'h0);
        step(1'b1, 32'h1600_0100, 33'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule